// File: doc/BRIEF.md
# Streaming bit-matrix address permutation

This block reorders a continuous stream of datasets. Each dataset has 2^N elements and arrives over 2^(N-K) cycles, with 2^K elements per cycle. Every element has an N-bit source address, which is its cycle number within the dataset followed by its port number. It leaves at the destination address given by multiplying an invertible N-by-N matrix over GF(2) with that source address. The matrices are compile-time parameters held in a list, and consecutive datasets take consecutive matrices, wrapping back to the first. Bit reversal and the identity are both special cases. A 100 MHz-class pipeline can feed datasets back to back with no idle cycles, and a dataset may also begin after any number of idle cycles.

The write side scatters each incoming element into a double-buffered set of 2^K banks, each 2^(N-K) rows deep. The element goes to the bank and row named by its destination address. The read side then drains the finished buffer row by row, in address order, while the write side fills the other buffer. The two sides keep separate address counters and communicate through one handoff pulse.

Write controller states: `W_IDLE` moves to `W_FILL` when a start strobe arrives, and writes row 0 in that cycle. `W_FILL` writes rows 1 through the last row. After the last row it returns to `W_IDLE` and raises the handoff pulse. Read controller states: `R_IDLE` moves to `R_DRAIN` on the handoff pulse. `R_DRAIN` issues one row per cycle. After the last row it returns to `R_IDLE`, unless a handoff arrives in that same cycle, in which case it stays in `R_DRAIN` and restarts at row 0.

Top module: `bitmat_stream_perm`

## Requirements
- R1: After reset, `out_valid_o` stays low until a complete dataset has been accepted.
- R2: Element p of input cycle t (t counted from the start cycle) has source address s = t*2^K + p. It appears at output row d >> K, on port d mod 2^K, where d = M*s over GF(2). Matrix row r (counted from 0) produces destination bit N-1-r. Column c multiplies source bit N-1-c. Port p occupies data bits [p*DATA_W +: DATA_W]. Matrix i is the i-th N*N-bit slice of `MATS`, counted from the most significant end, and the most significant bit of that slice is row 0, column 0.
- R3: The first dataset after reset uses matrix 0, the next uses matrix 1, and so on. After matrix NUM_MAT-1 the list wraps back to matrix 0.
- R4: If the start strobe is sampled at clock edge S, output row 0 is valid after edge S + 2^(N-K). The remaining rows follow on the next consecutive edges.
- R5: A new start strobe may arrive in the cycle right after the last input row of the previous dataset. The output rows of the two datasets are then contiguous, with no idle cycle between them.
- R6: A start strobe that arrives while a dataset is still being filled, after its first row, is ignored. The data in that cycle still belongs to the current dataset, and the matrix rotation does not advance.
- R7: `out_valid_o` is high for exactly 2^(N-K) cycles per dataset and is low at all other times, including during gaps between datasets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Marks the first input row of a dataset |
| in_data_i | input | 2^K*DATA_W | One input row, port p in bits [p*DATA_W +: DATA_W] |
| out_data_o | output | 2^K*DATA_W | One permuted output row, same packing |
| out_valid_o | output | 1 | High while `out_data_o` carries an output row |

## Verification
The assertions assume that each start strobe is followed by exactly 2^(N-K) rows of input. They also assume the next start comes no sooner than the cycle after that dataset's last row, so a handoff always meets an idle or finishing read controller. Given that, the two buffers never collide. The stimulus tasks always drive whole datasets, either back to back or separated by idle gaps. The only extra start strobe they send lands inside a dataset being filled, which is the case the block is required to ignore.

// File: rtl/bsp_pkg.sv
package bsp_pkg;

    localparam int unsigned MAX_N = 8;

    typedef enum logic {W_IDLE, W_FILL} wr_state_e;
    typedef enum logic {R_IDLE, R_DRAIN} rd_state_e;

    // Matrix-vector product over GF(2). Row r of the matrix sits in
    // bits [(n-1-r)*n +: n]; column c is bit n-1-c of that row and
    // multiplies source bit n-1-c. Row r yields destination bit n-1-r.
    function automatic logic [MAX_N-1:0] gf2_apply(
        input logic [MAX_N*MAX_N-1:0] mat,
        input logic [MAX_N-1:0]       src,
        input int unsigned            n
    );
        logic [MAX_N-1:0] dst;
        dst = '0;
        for (int unsigned r = 0; r < MAX_N; r++) begin
            for (int unsigned c = 0; c < MAX_N; c++) begin
                if (r < n && c < n) begin
                    if (mat[(n-1-r)*n + (n-1-c)] && src[n-1-c]) begin
                        dst[n-1-r] = ~dst[n-1-r];
                    end
                end
            end
        end
        return dst;
    endfunction

endpackage

// File: rtl/bsp_wr_ctrl.sv
module bsp_wr_ctrl
    import bsp_pkg::*;
#(
    parameter int unsigned N       = 3,
    parameter int unsigned K       = 1,
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned NUM_MAT = 2,
    parameter logic [NUM_MAT*N*N-1:0] MATS = '0
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start_i,
    input  logic [(1<<K)*DATA_W-1:0]      in_data_i,
    output logic                          we_o,
    output logic                          wr_buf_o,
    output logic [(1<<K)-1:0][K-1:0]      wr_bank_o,
    output logic [(1<<K)-1:0][N-K-1:0]    wr_row_o,
    output logic [(1<<K)-1:0][DATA_W-1:0] wr_data_o,
    output logic                          handoff_o
);
    localparam int unsigned P     = 1 << K;
    localparam int unsigned C     = 1 << (N - K);
    localparam int unsigned ROW_W = N - K;
    localparam int unsigned NN    = N * N;
    localparam int unsigned MI_W  = (NUM_MAT > 1) ? $clog2(NUM_MAT) : 1;

    wr_state_e        state_q, state_d;
    logic [ROW_W-1:0] cnt_q;
    logic [ROW_W-1:0] cur_row;
    logic [MI_W-1:0]  mat_idx_q;
    logic             buf_q;
    logic             last_row;
    logic [NN-1:0]    cur_mat;
    logic [P-1:0][N-1:0] dest;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= W_IDLE;
        else        state_q <= state_d;
    end

    // next state and per-cycle write control
    always_comb begin
        state_d  = state_q;
        we_o     = 1'b0;
        last_row = 1'b0;
        cur_row  = cnt_q;
        unique case (state_q)
            W_IDLE: begin
                if (start_i) begin
                    we_o     = 1'b1;
                    cur_row  = '0;
                    last_row = (C == 1);
                    state_d  = (C == 1) ? W_IDLE : W_FILL;
                end
            end
            W_FILL: begin
                we_o = 1'b1;
                if (cnt_q == ROW_W'(C - 1)) begin
                    last_row = 1'b1;
                    state_d  = W_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            mat_idx_q <= '0;
            buf_q     <= 1'b0;
        end else if (we_o) begin
            cnt_q <= last_row ? '0 : cur_row + ROW_W'(1);
            if (last_row) begin
                buf_q     <= ~buf_q;
                mat_idx_q <= (mat_idx_q == MI_W'(NUM_MAT - 1)) ? '0 : mat_idx_q + MI_W'(1);
            end
        end
    end

    always_comb begin
        cur_mat = MATS[(NUM_MAT - 1 - int'(mat_idx_q)) * NN +: NN];
    end

    // destination address per port
    for (genvar p = 0; p < P; p++) begin : g_port
        logic [N-1:0]     src;
        logic [MAX_N-1:0] dst_full;
        always_comb begin
            src          = {cur_row, K'(p)};
            dst_full     = gf2_apply((MAX_N*MAX_N)'(cur_mat), MAX_N'(src), N);
            dest[p]      = dst_full[N-1:0];
            wr_bank_o[p] = dest[p][K-1:0];
            wr_row_o[p]  = dest[p][N-1:K];
            wr_data_o[p] = in_data_i[p*DATA_W +: DATA_W];
        end
    end

    assign wr_buf_o  = buf_q;
    assign handoff_o = we_o && last_row;

    // invertible matrix: no two ports of one cycle share a destination
    always_comb begin
        if (rst_n && we_o) begin
            for (int i = 0; i < int'(P); i++) begin
                for (int j = i + 1; j < int'(P); j++) begin
                    AST_DEST_DISTINCT: assert (dest[i] != dest[j]) else $error("dest clash"); // R2
                end
            end
        end
    end

endmodule

// File: rtl/bsp_bank_store.sv
module bsp_bank_store #(
    parameter int unsigned N      = 3,
    parameter int unsigned K      = 1,
    parameter int unsigned DATA_W = 8
) (
    input  logic                          clk,
    input  logic                          we_i,
    input  logic                          wr_buf_i,
    input  logic [(1<<K)-1:0][K-1:0]      wr_bank_i,
    input  logic [(1<<K)-1:0][N-K-1:0]    wr_row_i,
    input  logic [(1<<K)-1:0][DATA_W-1:0] wr_data_i,
    input  logic                          rd_buf_i,
    input  logic [N-K-1:0]                rd_row_i,
    output logic [(1<<K)-1:0][DATA_W-1:0] rd_data_o
);
    localparam int unsigned P = 1 << K;
    localparam int unsigned C = 1 << (N - K);

    for (genvar b = 0; b < P; b++) begin : g_bank
        logic [DATA_W-1:0] cell_q [2][C];

        // any port whose destination lands in this bank writes it
        always_ff @(posedge clk) begin
            for (int p = 0; p < int'(P); p++) begin
                if (we_i && wr_bank_i[p] == K'(b)) begin
                    cell_q[wr_buf_i][wr_row_i[p]] <= wr_data_i[p];
                end
            end
        end

        assign rd_data_o[b] = cell_q[rd_buf_i][rd_row_i];
    end

endmodule

// File: rtl/bsp_rd_ctrl.sv
module bsp_rd_ctrl
    import bsp_pkg::*;
#(
    parameter int unsigned N      = 3,
    parameter int unsigned K      = 1,
    parameter int unsigned DATA_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          handoff_i,
    input  logic                          src_buf_i,
    input  logic [(1<<K)-1:0][DATA_W-1:0] row_data_i,
    output logic                          rd_buf_o,
    output logic [N-K-1:0]                rd_row_o,
    output logic                          rd_active_o,
    output logic [(1<<K)*DATA_W-1:0]      out_data_o,
    output logic                          out_valid_o
);
    localparam int unsigned C     = 1 << (N - K);
    localparam int unsigned ROW_W = N - K;

    rd_state_e        state_q, state_d;
    logic [ROW_W-1:0] cnt_q;
    logic             buf_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= R_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            R_IDLE:  if (handoff_i) state_d = R_DRAIN;
            R_DRAIN: if (cnt_q == ROW_W'(C - 1)) state_d = handoff_i ? R_DRAIN : R_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            buf_q <= 1'b0;
        end else if (handoff_i) begin
            cnt_q <= '0;
            buf_q <= src_buf_i;
        end else if (state_q == R_DRAIN) begin
            cnt_q <= cnt_q + ROW_W'(1);
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid_o <= 1'b0;
            out_data_o  <= '0;
        end else begin
            out_valid_o <= (state_q == R_DRAIN);
            if (state_q == R_DRAIN) out_data_o <= row_data_i;
        end
    end

    assign rd_buf_o    = buf_q;
    assign rd_row_o    = cnt_q;
    assign rd_active_o = (state_q == R_DRAIN);

    AST_DRAIN_READY: assert property (@(posedge clk) disable iff (!rst_n)
        handoff_i |-> (state_q == R_IDLE || cnt_q == ROW_W'(C - 1))) else $error("handoff mid-drain"); // R5
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        handoff_i |-> ##2 out_valid_o) else $error("no output after handoff"); // R4

endmodule

// File: rtl/bitmat_stream_perm.sv
module bitmat_stream_perm #(
    parameter int unsigned N_LOG   = 3,
    parameter int unsigned K_LOG   = 1,
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned NUM_MAT = 2,
    parameter logic [NUM_MAT*N_LOG*N_LOG-1:0] MATS = 18'b001_010_100_100_110_111
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              start_i,
    input  logic [(1<<K_LOG)*DATA_W-1:0]      in_data_i,
    output logic [(1<<K_LOG)*DATA_W-1:0]      out_data_o,
    output logic                              out_valid_o
);
    localparam int unsigned P     = 1 << K_LOG;
    localparam int unsigned ROW_W = N_LOG - K_LOG;

    logic                          we;
    logic                          wr_buf;
    logic [P-1:0][K_LOG-1:0]       wr_bank;
    logic [P-1:0][ROW_W-1:0]       wr_row;
    logic [P-1:0][DATA_W-1:0]      wr_data;
    logic                          handoff;
    logic                          rd_buf;
    logic [ROW_W-1:0]              rd_row;
    logic                          rd_active;
    logic [P-1:0][DATA_W-1:0]      rd_data;

    bsp_wr_ctrl #(
        .N(N_LOG), .K(K_LOG), .DATA_W(DATA_W), .NUM_MAT(NUM_MAT), .MATS(MATS)
    ) wr_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .in_data_i(in_data_i),
        .we_o(we), .wr_buf_o(wr_buf), .wr_bank_o(wr_bank), .wr_row_o(wr_row),
        .wr_data_o(wr_data), .handoff_o(handoff)
    );

    bsp_bank_store #(.N(N_LOG), .K(K_LOG), .DATA_W(DATA_W)) store_i (
        .clk(clk), .we_i(we), .wr_buf_i(wr_buf), .wr_bank_i(wr_bank),
        .wr_row_i(wr_row), .wr_data_i(wr_data), .rd_buf_i(rd_buf),
        .rd_row_i(rd_row), .rd_data_o(rd_data)
    );

    bsp_rd_ctrl #(.N(N_LOG), .K(K_LOG), .DATA_W(DATA_W)) rd_i (
        .clk(clk), .rst_n(rst_n), .handoff_i(handoff), .src_buf_i(wr_buf),
        .row_data_i(rd_data), .rd_buf_o(rd_buf), .rd_row_o(rd_row),
        .rd_active_o(rd_active), .out_data_o(out_data_o), .out_valid_o(out_valid_o)
    );

    AST_BUF_SEPARATE: assert property (@(posedge clk) disable iff (!rst_n)
        (we && rd_active) |-> (wr_buf != rd_buf)) else $error("buffer collision"); // R5

endmodule

// File: tb/bitmat_stream_perm_tb_top.sv
module bitmat_stream_perm_tb_top;
    localparam int N  = 3;
    localparam int K  = 1;
    localparam int W  = 8;
    localparam int NM = 2;
    localparam int P  = 1 << K;
    localparam int C  = 1 << (N - K);
    localparam int NE = 1 << N;
    localparam logic [NM*N*N-1:0] MATS = 18'b001_010_100_100_110_111;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [P*W-1:0]   in_data = '0;
    logic [P*W-1:0]   out_data;
    logic             out_valid;

    int errors = 0, checks = 0, cyc = 0, ds_next = 0;
    int start_edge = 0, first_cyc = -1, last_cyc = -1, rise_cyc = -1, rows_seen = 0;
    logic prev_valid = 1'b0;
    string cur_tag = "R2";
    logic [P*W-1:0] exp_q[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    bitmat_stream_perm #(.N_LOG(N), .K_LOG(K), .DATA_W(W), .NUM_MAT(NM), .MATS(MATS)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .in_data_i(in_data),
        .out_data_o(out_data), .out_valid_o(out_valid)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // software model of the GF(2) address map (R2 conventions)
    function automatic int tb_dest(input int mi, input int s);
        int d = 0;
        for (int r = 0; r < N; r++) begin
            for (int c = 0; c < N; c++) begin
                if (MATS[(NM-mi)*N*N - 1 - (r*N + c)] && ((s >> (N-1-c)) & 1) == 1) d ^= 1 << (N-1-r);
            end
        end
        return d;
    endfunction

    // monitor
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (!prev_valid) rise_cyc = cyc;
            if (rows_seen == 0) first_cyc = cyc;
            last_cyc = cyc;
            rows_seen++;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R7", "valid with no dataset pending", 1, 0);
            end else begin
                logic [P*W-1:0] e;
                e = exp_q.pop_front();
                chk(out_data == e, cur_tag, "output row", int'(out_data), int'(e));
            end
        end
        prev_valid = out_valid;
    end

    task automatic send_dataset(input int base, input bit glitch);
        logic [W-1:0] e [NE];
        int mi = ds_next % NM;
        ds_next++;
        for (int s = 0; s < NE; s++) e[tb_dest(mi, s)] = W'(base + s);
        for (int r = 0; r < C; r++) begin
            logic [P*W-1:0] row;
            for (int p = 0; p < P; p++) row[p*W +: W] = e[r*P + p];
            exp_q.push_back(row);
        end
        for (int t = 0; t < C; t++) begin
            @(negedge clk);
            if (t == 0) start_edge = cyc + 1;
            start = (t == 0) || (glitch && t == 1);
            for (int p = 0; p < P; p++) in_data[p*W +: W] = W'(base + t*P + p);
        end
    endtask

    task automatic go_idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            start = 1'b0;
            in_data = P*W'($urandom);
        end
    endtask

    task automatic drain();
        go_idle(1);
        for (int i = 0; i < 40 && exp_q.size() != 0; i++) go_idle(1);
        go_idle(2);
    endtask

    task automatic clear_stats();
        rows_seen = 0; first_cyc = -1; last_cyc = -1; rise_cyc = -1;
    endtask

    task automatic t_reset();
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(out_valid == 1'b0, "R1", "valid after reset", int'(out_valid), 0);
        end
    endtask

    task automatic t_single();
        clear_stats(); cur_tag = "R2";
        send_dataset(8'h10, 1'b0);
        drain();
        chk(rise_cyc == start_edge + C, "R4", "first valid edge", rise_cyc, start_edge + C);
        chk(rows_seen == C, "R7", "rows per dataset", rows_seen, C);
    endtask

    task automatic t_back_to_back();
        clear_stats(); cur_tag = "R3";
        for (int d = 0; d < 5; d++) send_dataset(8'h40 + d*16, 1'b0);
        drain();
        chk(rows_seen == 5*C, "R5", "rows for five datasets", rows_seen, 5*C);
        chk(last_cyc - first_cyc + 1 == 5*C, "R5", "contiguous output span", last_cyc - first_cyc + 1, 5*C);
    endtask

    task automatic t_glitch_start();
        clear_stats(); cur_tag = "R6";
        send_dataset(8'h90, 1'b1);
        send_dataset(8'hA0, 1'b0);
        drain();
        chk(rows_seen == 2*C, "R6", "rows with extra start", rows_seen, 2*C);
    endtask

    task automatic t_gap();
        clear_stats(); cur_tag = "R7";
        send_dataset(8'hC0, 1'b0);
        go_idle(7);
        send_dataset(8'hD0, 1'b0);
        drain();
        chk(rows_seen == 2*C, "R7", "rows around gap", rows_seen, 2*C);
        chk(rise_cyc == start_edge + C, "R4", "first valid after gap", rise_cyc, start_edge + C);
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        go_idle(3);
        rst_n = 1'b1;
        t_reset();
        t_single();
        t_back_to_back();
        t_glitch_start();
        t_gap();
        chk(exp_q.size() == 0, "R7", "pending rows at end", exp_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule